// File: doc/BRIEF.md
# Radix-4 Iterative Unsigned Divider

This block divides one unsigned word by another and returns both the quotient and the remainder. It settles two quotient bits per clock. Each step forms the partial remainder shifted left by two with the next two dividend bits appended. It then tries to subtract one, two and three times the divisor in parallel and keeps the largest trial that does not go negative. Triple the divisor is formed once, before the first step. The other two multiples are plain wiring.

Before the loop starts, the block counts the leading zeros of both operands. From the two counts it knows how many quotient bits can be non-zero. The dividend bits that lie above that range are loaded directly as the starting remainder, so no step is spent on them. While the loop runs, the block finishes at once if both the partial remainder and the dividend bits not yet consumed are zero. In that case the quotient is simply shifted into place. Two cases bypass the loop entirely and finish one cycle after acceptance: a zero divisor, and a dividend smaller than the divisor. As a result, latency depends on the operands.

Requests enter on a valid/ready handshake. `req_ready` is high only while the block is idle, so a request offered while it is busy waits with `req_valid` held; it is not queued. Results leave on a one-cycle `res_valid` pulse with no back-pressure. The consumer must take the result in that cycle, or read `quotient` and `remainder` later, because they hold until the next accepted request. The width parameter `W` must be even. In the text below, "k cycles" means that `res_valid` is high in the k-th cycle after the clock edge that accepted the request.

Top module: `radix4_divider`

## Requirements
- R1: For a non-zero divisor, the result satisfies dividend = quotient*divisor + remainder with remainder < divisor, and `div_by_zero` is 0.
- R2: A zero divisor gives a result after 1 cycle with `div_by_zero`=1, the quotient all ones and the remainder equal to the dividend.
- R3: A dividend smaller than a non-zero divisor (a zero dividend included) gives a result after 1 cycle with quotient 0, the remainder equal to the dividend and `div_by_zero`=0.
- R4: `busy` is high and `req_ready` is low from the accepting edge until the cycle in which `res_valid` rises. While `req_ready` is low, `req_valid` and the operand inputs have no effect on the result.
- R5: `quotient`, `remainder` and `div_by_zero` hold their values from `res_valid` until the next accepted request.
- R6: When the dividend is at least the divisor, let n = clz(divisor) - clz(dividend) + 1, where clz counts leading zeros. The result arrives within ceil(n/2)+2 cycles, and never later than W/2+2 cycles. The all-ones dividend divided by 1 takes exactly W/2+2 cycles.
- R7: Early exit: once the partial remainder and the unconsumed dividend bits are both zero, the next cycle posts the result. For example, 2^(W-1) divided by 1 completes in 4 cycles.
- R8: `res_valid` is high for one cycle per accepted request, and it is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_dividend | input | W | Dividend, sampled on acceptance |
| req_divisor | input | W | Divisor, sampled on acceptance |
| busy | output | 1 | A divide is in progress |
| res_valid | output | 1 | One-cycle pulse: result is posted |
| quotient | output | W | Quotient, held until the next accepted request |
| remainder | output | W | Remainder, held until the next accepted request |
| div_by_zero | output | 1 | Last result came from a zero divisor |

## Verification
The bench covers the two single-cycle bypasses: a zero divisor and a small or zero dividend. A design that mishandled them would return the wrong fill value or fall into the loop and arrive late.

Several cases would expose a wrong starting remainder from pre-normalization: odd and even quotient widths, a divisor of one, powers of two, and a dividend only just above the divisor. The all-ones dividend cannot exit early, so it pins the worst-case step count. An exact power of two must exit early, so it catches both a missing shift of the quotient and a missing exit. Junk requests held during a long divide would corrupt the result if the busy gate leaked.

// File: rtl/divr4_pkg.sv
package divr4_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_RUN  = 2'd2
  } div_state_e;
endpackage

// File: rtl/divr4_lzc.sv
module divr4_lzc #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  value,
  output logic [CW-1:0] count
);
  // The lowest set bit is visited first and the highest set bit last,
  // so the final assignment comes from the most significant one.
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (value[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/divr4_step.sv
module divr4_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_in,
  input  logic [1:0]   bits_in,
  input  logic [W-1:0] dsr,
  input  logic [W+1:0] dsr3,
  output logic [1:0]   digit,
  output logic [W-1:0] rem_out
);
  logic [W+2:0] ext, t1, t2, t3;

  // The three trial subtractions run side by side; the MSB of each is its sign.
  always_comb begin
    ext = {1'b0, rem_in, bits_in};
    t1  = ext - {3'b000, dsr};
    t2  = ext - {2'b00, dsr, 1'b0};
    t3  = ext - {1'b0, dsr3};
    if (!t3[W+2]) begin
      digit   = 2'd3;
      rem_out = t3[W-1:0];
    end else if (!t2[W+2]) begin
      digit   = 2'd2;
      rem_out = t2[W-1:0];
    end else if (!t1[W+2]) begin
      digit   = 2'd1;
      rem_out = t1[W-1:0];
    end else begin
      digit   = 2'd0;
      rem_out = ext[W-1:0];
    end
  end
endmodule

// File: rtl/radix4_divider.sv
module radix4_divider
  import divr4_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] req_dividend,
  input  logic [W-1:0] req_divisor,
  output logic         busy,
  output logic         res_valid,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero
);
  localparam int CW  = $clog2(W + 1);
  localparam int HW  = W / 2;
  localparam int SCW = $clog2(HW + 1);

  div_state_e      state;
  logic [W-1:0]    a_r, b_r, dvd_r, rem_r, q_r;
  logic [W+1:0]    d3_r;
  logic [SCW-1:0]  cnt_r;
  logic            dbz_r, vld_r;

  logic [CW-1:0]   lz_a, lz_b;
  logic [CW:0]     nbits, steps, sh_lo, sh_hi;
  logic [1:0]      digit;
  logic [W-1:0]    rem_nx;
  logic            accept, exit_now;

  divr4_lzc #(.W(W)) u_lz_a (.value(a_r), .count(lz_a));
  divr4_lzc #(.W(W)) u_lz_b (.value(b_r), .count(lz_b));

  divr4_step #(.W(W)) u_step (
    .rem_in (rem_r),
    .bits_in(dvd_r[W-1:W-2]),
    .dsr    (b_r),
    .dsr3   (d3_r),
    .digit  (digit),
    .rem_out(rem_nx)
  );

  // Derived step count: n significant quotient bits, rounded up to whole radix-4 digits.
  always_comb begin
    nbits = {1'b0, lz_b} - {1'b0, lz_a} + (CW+1)'(1);
    steps = (nbits + (CW+1)'(1)) >> 1;
    sh_lo = steps << 1;
    sh_hi = (CW+1)'(W) - sh_lo;
  end

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign exit_now  = (rem_r == '0) && (dvd_r == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      a_r   <= '0;
      b_r   <= '0;
      d3_r  <= '0;
      dvd_r <= '0;
      rem_r <= '0;
      q_r   <= '0;
      cnt_r <= '0;
      dbz_r <= 1'b0;
      vld_r <= 1'b0;
    end else begin
      vld_r <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            dbz_r <= (req_divisor == '0);
            if (req_divisor == '0) begin
              q_r   <= '1;
              rem_r <= req_dividend;
              vld_r <= 1'b1;
            end else if (req_dividend < req_divisor) begin
              q_r   <= '0;
              rem_r <= req_dividend;
              vld_r <= 1'b1;
            end else begin
              a_r   <= req_dividend;
              b_r   <= req_divisor;
              state <= ST_PREP;
            end
          end
        end
        ST_PREP: begin
          d3_r  <= {2'b00, b_r} + {1'b0, b_r, 1'b0};
          rem_r <= a_r >> sh_lo;
          dvd_r <= a_r << sh_hi;
          q_r   <= '0;
          cnt_r <= SCW'(steps);
          state <= ST_RUN;
        end
        ST_RUN: begin
          if (exit_now) begin
            q_r   <= q_r << {cnt_r, 1'b0};
            vld_r <= 1'b1;
            state <= ST_IDLE;
          end else begin
            q_r   <= {q_r[W-3:0], digit};
            rem_r <= rem_nx;
            dvd_r <= dvd_r << 2;
            cnt_r <= cnt_r - SCW'(1);
            if (cnt_r == SCW'(1)) begin
              vld_r <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign res_valid   = vld_r;
  assign quotient    = q_r;
  assign remainder   = rem_r;
  assign div_by_zero = dbz_r;
endmodule

// File: rtl/radix4_divider_chk.sv
module radix4_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic [W-1:0] req_dividend,
  input logic [W-1:0] req_divisor,
  input logic         busy,
  input logic         res_valid,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         div_by_zero
);
  localparam int LW = $clog2(W + 8);

  logic [W-1:0]   cap_a, cap_b;
  logic [LW-1:0]  lat;
  logic [2*W-1:0] recon, want;
  logic           acc;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
      lat   <= '0;
    end else if (acc) begin
      cap_a <= req_dividend;
      cap_b <= req_divisor;
      lat   <= LW'(1);
    end else if (busy) begin
      lat   <= lat + LW'(1);
    end
  end

  always_comb begin
    recon = {{W{1'b0}}, quotient} * {{W{1'b0}}, cap_b} + {{W{1'b0}}, remainder};
    want  = {{W{1'b0}}, cap_a};
  end

  p_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !div_by_zero) |-> (recon == want) && (remainder < cap_b));

  p_zero_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_divisor == '0) |=> (res_valid && div_by_zero && (&quotient)));

  p_small_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_divisor != '0 && req_dividend < req_divisor)
      |=> (res_valid && !div_by_zero && quotient == '0 && remainder == $past(req_dividend)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !acc) |=> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (lat <= LW'(W / 2 + 2)));

  p_no_pulse_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !res_valid);
endmodule

bind radix4_divider radix4_divider_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_dividend(req_dividend), .req_divisor(req_divisor), .busy(busy),
  .res_valid(res_valid), .quotient(quotient), .remainder(remainder),
  .div_by_zero(div_by_zero)
);

// File: tb/radix4_divider_test.sv
module radix4_divider_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [W-1:0] req_dividend = '0;
  logic [W-1:0] req_divisor = '0;
  logic         busy, res_valid, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  radix4_divider #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dividend(req_dividend), .req_divisor(req_divisor), .busy(busy),
    .res_valid(res_valid), .quotient(quotient), .remainder(remainder),
    .div_by_zero(div_by_zero)
  );

  function automatic int clz(input logic [W-1:0] v);
    int c = W;
    for (int i = 0; i < W; i++) if (v[i]) c = W - 1 - i;
    return c;
  endfunction

  function automatic int lat_bound(input logic [W-1:0] a, input logic [W-1:0] b);
    if (b == '0 || a < b) return 1;
    return (clz(b) - clz(a) + 2) / 2 + 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // exact_lat < 0 means only the bound applies; junk holds a bogus request while busy.
  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                         input int exact_lat, input bit junk, input string tag);
    int k;
    logic [W-1:0] eq, er;
    while (!req_ready) @(negedge clk);
    req_valid    = 1'b1;
    req_dividend = a;
    req_divisor  = b;
    @(negedge clk);
    if (junk) begin
      req_dividend = ~a;
      req_divisor  = 32'd3;
    end else begin
      req_valid = 1'b0;
    end
    k = 1;
    while (!res_valid && k < 100) begin
      if (k == 2) req_valid = 1'b0;
      @(negedge clk);
      k++;
    end
    req_valid = 1'b0;
    if (b == '0) begin
      eq = '1;
      er = a;
    end else begin
      eq = a / b;
      er = a % b;
    end
    chk(res_valid, tag, "res_valid seen (watchdog)", 64'(res_valid), 64'd1);
    chk(quotient == eq, tag, "quotient", 64'(quotient), 64'(eq));
    chk(remainder == er, tag, "remainder", 64'(remainder), 64'(er));
    chk(div_by_zero == (b == '0), tag, "div_by_zero", 64'(div_by_zero), 64'(b == '0));
    if (exact_lat >= 0)
      chk(k == exact_lat, tag, "latency exact", 64'(k), 64'(exact_lat));
    else
      chk(k <= lat_bound(a, b), tag, "latency bound R6", 64'(k), 64'(lat_bound(a, b)));
    @(negedge clk);
    chk(!res_valid, "R8", "pulse ends", 64'(res_valid), 64'd0);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] hq, hr;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy && !res_valid, "R4", "reset state", 64'({req_ready, busy, res_valid}), 64'b100);

    // R2: zero divisor
    run_div(32'd12345, 32'd0, 1, 1'b0, "R2");
    run_div(32'hFFFF_FFFF, 32'd0, 1, 1'b0, "R2");
    // R3: small or zero dividend
    run_div(32'd0, 32'd7, 1, 1'b0, "R3");
    run_div(32'd99, 32'd100, 1, 1'b0, "R3");
    // R6: worst case, no early exit possible
    run_div(32'hFFFF_FFFF, 32'd1, W/2 + 2, 1'b0, "R6");
    run_div(32'hFFFF_FFFF, 32'h8000_0000, 3, 1'b0, "R6");
    // R7: early exit
    run_div(32'h8000_0000, 32'd1, 4, 1'b0, "R7");
    run_div(32'h0001_0000, 32'd16, -1, 1'b0, "R7");
    // R1: assorted directed
    run_div(32'd100, 32'd100, -1, 1'b0, "R1");
    run_div(32'd101, 32'd100, -1, 1'b0, "R1");
    run_div(32'hDEAD_BEEF, 32'd1, -1, 1'b0, "R1");
    run_div(32'hDEAD_BEEF, 32'd3, -1, 1'b0, "R1");
    run_div(32'h7FFF_FFFF, 32'h0000_0002, -1, 1'b0, "R1");
    // R4: junk request held while busy must be ignored
    run_div(32'hFFFF_FFFE, 32'd5, -1, 1'b1, "R4");

    // R5: results hold while idle
    hq = quotient;
    hr = remainder;
    repeat (4) @(negedge clk);
    chk(quotient == hq && remainder == hr, "R5", "hold while idle", 64'(quotient), 64'(hq));

    // R1: constrained random
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b;
      a = $urandom >> ($urandom % 8);
      b = $urandom >> ($urandom % W);
      if (($urandom % 16) == 0) b = '0;
      run_div(a, b, -1, 1'b0, "R1");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule